// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a 16-bit set of sticky flags that tell software what happened before the latest reset or low-power entry. Each flag is raised by a one-cycle event strobe: power-on, brown-out, external pin reset, software reset instruction, watchdog timeout, trap conflict, illegal opcode, configuration mismatch, sleep entry, idle entry, and deep-sleep entry. Each flag also has its own clearing events. Software can write any implemented flag to 0 or 1. A write only changes the register and never requests a reset.

The block also chooses the 3-bit clock source code that applies after a reset. With clock switching disabled, the code is always the configured oscillator selection. With clock switching enabled, it depends on the kind of reset:
- Power-on and brown-out resets reload the configured selection.
- Pin, watchdog and software resets keep the oscillator that is currently running.

The code is latched on the cycle the reset event arrives. It is held until the next such event.

Top module: `rstcause_top`

## Requirements
- R1: After the synchronous reset `rst`, `rd_data` reads 0x0000 and `clk_src` reads 0.
- R2: Each event sets its flag one cycle after its strobe, at these bit positions: trap 15, illegal opcode 14, deep sleep 10, configuration mismatch 9, pin reset 7, software reset 6, watchdog 4, sleep 3, idle 2, brown-out 1, power-on 0.
- R3: A power-on strobe leaves `rd_data` at exactly 0x0003, which clears every other flag. A brown-out strobe alone sets only bit 1.
- R4: A sleep strobe sets bit 3. It also sets bit 10 only while `dsleep_en` is high.
- R5: A sleep or idle strobe clears bit 4, unless a watchdog strobe arrives in the same cycle.
- R6: When `wr_en` is high, the implemented bits take `wr_data` on the next cycle, with mask 0xC6DF. Bits 5, 8, 11, 12 and 13 always read 0.
- R7: If an event strobe and a write target the same bit in the same cycle, the event's effect wins.
- R8: With no strobe and no write, every flag holds its value.
- R9: With `cksw_en` low, any reset strobe (power-on, brown-out, pin, software or watchdog) loads `cfg_osc` into `clk_src` on the next cycle.
- R10: With `cksw_en` high, a power-on or brown-out strobe loads `cfg_osc`, and a pin, software or watchdog strobe loads `cur_osc`.
- R11: Between reset strobes, `clk_src` holds its value whatever `cfg_osc` and `cur_osc` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| ev_por | input | 1 | Power-on event strobe |
| ev_bor | input | 1 | Brown-out event strobe |
| ev_pin | input | 1 | External pin reset strobe |
| ev_swrst | input | 1 | Reset instruction strobe |
| ev_wdt | input | 1 | Watchdog timeout strobe |
| ev_trap | input | 1 | Trap conflict strobe |
| ev_illop | input | 1 | Illegal opcode / uninitialized register strobe |
| ev_cfgmis | input | 1 | Configuration mismatch strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_idle | input | 1 | Idle entry strobe |
| dsleep_en | input | 1 | Deep-sleep enable, qualifies sleep entry |
| wr_en | input | 1 | Register write enable |
| wr_data | input | 16 | Register write data |
| cksw_en | input | 1 | Clock switching enabled |
| cfg_osc | input | 3 | Configured oscillator selection |
| cur_osc | input | 3 | Currently running oscillator selection |
| rd_data | output | 16 | Flag register value |
| clk_src | output | 3 | Post-reset clock source code |

## Verification
The bench raises each strobe on its own so that every flag is tied to its bit position. It then combines strobes in the same cycle: a watchdog timeout together with idle entry shows that the set wins over the power-save clear. A write landing on top of a brown-out or watchdog strobe separates write priority from event priority. An all-ones write followed by an all-zeros write exposes the unused bits. Each reset type is applied with clock switching both off and on, and the oscillator inputs are changed between resets. This tells the configured-selection path, the current-selection path and the hold behaviour apart.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned OSC_W   = 3;
  localparam int unsigned B_TRAP  = 15;
  localparam int unsigned B_ILLOP = 14;
  localparam int unsigned B_DSLP  = 10;
  localparam int unsigned B_CFGM  = 9;
  localparam int unsigned B_PIN   = 7;
  localparam int unsigned B_SWR   = 6;
  localparam int unsigned B_WDT   = 4;
  localparam int unsigned B_SLP   = 3;
  localparam int unsigned B_IDLE  = 2;
  localparam int unsigned B_BOR   = 1;
  localparam int unsigned B_POR   = 0;
  localparam logic [REG_W-1:0] FLAG_MASK = 16'hC6DF;

  typedef struct packed {
    logic por;
    logic bor;
    logic pin;
    logic swrst;
    logic wdt;
    logic trap;
    logic illop;
    logic cfgmis;
    logic sleep;
    logic idle;
    logic dslp_en;
  } evt_t;
endpackage

// File: rtl/rstcause_evmap.sv
module rstcause_evmap
  import rstcause_pkg::*;
(
  input  evt_t             ev,
  output logic [REG_W-1:0] set_v,
  output logic [REG_W-1:0] clr_v
);
  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[B_TRAP]  = ev.trap;
    set_v[B_ILLOP] = ev.illop;
    set_v[B_DSLP]  = ev.sleep & ev.dslp_en;
    set_v[B_CFGM]  = ev.cfgmis;
    set_v[B_PIN]   = ev.pin;
    set_v[B_SWR]   = ev.swrst;
    set_v[B_WDT]   = ev.wdt;
    set_v[B_SLP]   = ev.sleep;
    set_v[B_IDLE]  = ev.idle;
    set_v[B_BOR]   = ev.bor | ev.por;
    set_v[B_POR]   = ev.por;
    clr_v[B_WDT]   = ev.sleep | ev.idle;
    if (ev.por) begin
      clr_v = ~set_v;
    end
  end
endmodule

// File: rtl/rstcause_flags.sv
module rstcause_flags
  import rstcause_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter logic [W-1:0] MASK = FLAG_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  input  logic         sleep_ev,
  input  logic         dslp_en,
  input  logic         idle_ev,
  input  logic         wdt_ev,
  input  logic         por_ev,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic d;
    always_comb begin
      if (MASK[i]) begin
        d = ((wr_en ? wr_data[i] : q[i]) & ~clr_v[i]) | set_v[i];
      end else begin
        d = 1'b0;
      end
    end
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d;
    end
  end

  AST_POR_EXACT: assert property (@(posedge clk) disable iff (rst)
    por_ev |=> (q == W'(3))); // R3
  AST_DSLP_SET: assert property (@(posedge clk) disable iff (rst)
    (sleep_ev && dslp_en) |=> (q[B_DSLP] && q[B_SLP])); // R4
  AST_WDT_CLR: assert property (@(posedge clk) disable iff (rst)
    ((sleep_ev || idle_ev) && !wdt_ev && !por_ev) |=> !q[B_WDT]); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && set_v == '0 && clr_v == '0) |=> $stable(q)); // R8
endmodule

// File: rtl/rstcause_clksel.sv
module rstcause_clksel
  import rstcause_pkg::*;
#(
  parameter int unsigned OW = OSC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cold_rst,
  input  logic          warm_rst,
  input  logic          cksw_en,
  input  logic [OW-1:0] cfg_osc,
  input  logic [OW-1:0] cur_osc,
  output logic [OW-1:0] clk_src
);
  logic          any_rst;
  logic          use_cfg;
  logic [OW-1:0] pick;

  assign any_rst = cold_rst | warm_rst;
  assign use_cfg = ~cksw_en | cold_rst;
  assign pick    = use_cfg ? cfg_osc : cur_osc;

  always_ff @(posedge clk) begin
    if (rst)          clk_src <= '0;
    else if (any_rst) clk_src <= pick;
  end

  AST_CK_CFG: assert property (@(posedge clk) disable iff (rst)
    (any_rst && !cksw_en) |=> (clk_src == $past(cfg_osc))); // R9
  AST_CK_WARM: assert property (@(posedge clk) disable iff (rst)
    (warm_rst && !cold_rst && cksw_en) |=> (clk_src == $past(cur_osc))); // R10
  AST_CK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !any_rst |=> $stable(clk_src)); // R11
endmodule

// File: rtl/rstcause_top.sv
module rstcause_top
  import rstcause_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_por,
  input  logic             ev_bor,
  input  logic             ev_pin,
  input  logic             ev_swrst,
  input  logic             ev_wdt,
  input  logic             ev_trap,
  input  logic             ev_illop,
  input  logic             ev_cfgmis,
  input  logic             ev_sleep,
  input  logic             ev_idle,
  input  logic             dsleep_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cksw_en,
  input  logic [OSC_W-1:0] cfg_osc,
  input  logic [OSC_W-1:0] cur_osc,
  output logic [REG_W-1:0] rd_data,
  output logic [OSC_W-1:0] clk_src
);
  evt_t             ev;
  logic [REG_W-1:0] set_v;
  logic [REG_W-1:0] clr_v;

  assign ev = '{por: ev_por, bor: ev_bor, pin: ev_pin, swrst: ev_swrst,
                wdt: ev_wdt, trap: ev_trap, illop: ev_illop,
                cfgmis: ev_cfgmis, sleep: ev_sleep, idle: ev_idle,
                dslp_en: dsleep_en};

  rstcause_evmap u_map (
    .ev    (ev),
    .set_v (set_v),
    .clr_v (clr_v)
  );

  rstcause_flags #(.W(REG_W), .MASK(FLAG_MASK)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .set_v    (set_v),
    .clr_v    (clr_v),
    .sleep_ev (ev_sleep),
    .dslp_en  (dsleep_en),
    .idle_ev  (ev_idle),
    .wdt_ev   (ev_wdt),
    .por_ev   (ev_por),
    .q        (rd_data)
  );

  rstcause_clksel #(.OW(OSC_W)) u_ck (
    .clk      (clk),
    .rst      (rst),
    .cold_rst (ev_por | ev_bor),
    .warm_rst (ev_pin | ev_swrst | ev_wdt),
    .cksw_en  (cksw_en),
    .cfg_osc  (cfg_osc),
    .cur_osc  (cur_osc),
    .clk_src  (clk_src)
  );

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((rd_data & ~FLAG_MASK) == '0)); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ev_pin) |=> rd_data[B_PIN]); // R7
endmodule

// File: tb/rstcause_top_tb_top.sv
module rstcause_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ev_por, ev_bor, ev_pin, ev_swrst, ev_wdt, ev_trap;
  logic        ev_illop, ev_cfgmis, ev_sleep, ev_idle, dsleep_en;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        cksw_en;
  logic [2:0]  cfg_osc, cur_osc;
  logic [15:0] rd_data;
  logic [2:0]  clk_src;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] exp_rd_q[$];
  logic [2:0]  exp_ck_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rstcause_top dut_i (
    .clk(clk), .rst(rst), .ev_por(ev_por), .ev_bor(ev_bor), .ev_pin(ev_pin),
    .ev_swrst(ev_swrst), .ev_wdt(ev_wdt), .ev_trap(ev_trap),
    .ev_illop(ev_illop), .ev_cfgmis(ev_cfgmis), .ev_sleep(ev_sleep),
    .ev_idle(ev_idle), .dsleep_en(dsleep_en), .wr_en(wr_en),
    .wr_data(wr_data), .cksw_en(cksw_en), .cfg_osc(cfg_osc),
    .cur_osc(cur_osc), .rd_data(rd_data), .clk_src(clk_src)
  );

  task automatic idle_inputs();
    ev_por = 0; ev_bor = 0; ev_pin = 0; ev_swrst = 0; ev_wdt = 0;
    ev_trap = 0; ev_illop = 0; ev_cfgmis = 0; ev_sleep = 0; ev_idle = 0;
    dsleep_en = 0; wr_en = 0; wr_data = '0; rst = 0;
  endtask

  // Driver: inputs are already set by the caller at a negedge; this queues
  // the expected result, lets one rising edge pass, then clears strobes.
  task automatic expect_step(input logic [15:0] erd, input logic [2:0] eck,
                             input string tag);
    exp_rd_q.push_back(erd);
    exp_ck_q.push_back(eck);
    tag_q.push_back(tag);
    @(negedge clk);
    idle_inputs();
  endtask

  // Monitor: samples 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (tag_q.size() > 0) begin
        logic [15:0] erd;
        logic [2:0]  eck;
        string       t;
        erd = exp_rd_q.pop_front();
        eck = exp_ck_q.pop_front();
        t   = tag_q.pop_front();
        checks++;
        if (rd_data !== erd || clk_src !== eck) begin
          errors++;
          $display("FAIL %s: rd_data=%h clk_src=%0d expected rd_data=%h clk_src=%0d",
                   t, rd_data, clk_src, erd, eck);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    cksw_en = 0; cfg_osc = 3'd5; cur_osc = 3'd2;
    @(negedge clk);
    rst = 1;
    expect_step(16'h0000, 3'd0, "R1 reset state");
    ev_por = 1;
    expect_step(16'h0003, 3'd5, "R3 R9 power-on");
    wr_en = 1; wr_data = 16'h0000;
    expect_step(16'h0000, 3'd5, "R6 write zero");
    wr_en = 1; wr_data = 16'hFFFF;
    expect_step(16'hC6DF, 3'd5, "R6 write ones, unused bits zero");
    ev_idle = 1;
    expect_step(16'hC6CF, 3'd5, "R5 idle clears watchdog flag");
    expect_step(16'hC6CF, 3'd5, "R8 flags sticky");
    ev_por = 1;
    expect_step(16'h0003, 3'd5, "R3 power-on clears others");
    wr_en = 1; wr_data = 16'h0000; ev_bor = 1;
    expect_step(16'h0002, 3'd5, "R3 R7 brown-out alone over write");
    cksw_en = 1;
    ev_pin = 1;
    expect_step(16'h0082, 3'd2, "R2 R10 pin reset keeps current osc");
    ev_wdt = 1;
    expect_step(16'h0092, 3'd2, "R2 R10 watchdog flag bit 4");
    ev_sleep = 1;
    expect_step(16'h008A, 3'd2, "R4 R5 sleep without deep-sleep");
    ev_sleep = 1; dsleep_en = 1;
    expect_step(16'h048A, 3'd2, "R4 deep-sleep bit 10");
    ev_trap = 1;
    expect_step(16'h848A, 3'd2, "R2 trap bit 15");
    ev_illop = 1;
    expect_step(16'hC48A, 3'd2, "R2 illegal opcode bit 14");
    ev_cfgmis = 1;
    expect_step(16'hC68A, 3'd2, "R2 config mismatch bit 9");
    ev_swrst = 1;
    expect_step(16'hC6CA, 3'd2, "R2 R10 software reset bit 6");
    cur_osc = 3'd6; cfg_osc = 3'd1;
    expect_step(16'hC6CA, 3'd2, "R11 clock source held");
    ev_bor = 1;
    expect_step(16'hC6CA, 3'd1, "R10 brown-out reloads configured osc");
    wr_en = 1; wr_data = 16'h0000; ev_wdt = 1;
    expect_step(16'h0010, 3'd6, "R7 R10 watchdog over write");
    ev_wdt = 1; ev_idle = 1;
    expect_step(16'h0014, 3'd6, "R5 watchdog with idle keeps flag");
    cksw_en = 0; ev_pin = 1;
    expect_step(16'h0094, 3'd1, "R9 pin reset with switching off");
    rst = 1;
    expect_step(16'h0000, 3'd0, "R1 reset again");
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule